// File: doc/BRIEF.md
# VLAN Violation Capture Unit

The forwarding path raises a one-cycle report whenever a frame breaks VLAN policy. Two kinds of break are reported. In a member violation, the source port does not belong to the VLAN. In a miss violation, the VLAN ID has no valid table entry. The unit keeps the first such report and drives a level interrupt while it holds it. Later reports are dropped, and a sticky overflow bit notes that something was lost.

The host does not read a status register. It issues a get-and-clear command on the operation interface. The unit is busy for one cycle. It then loads the held details into the shared result fields: the two kind flags, the source port, the 12-bit VLAN ID and its page bit. In the same step it frees the capture slot and drops the interrupt.

Top module: `vlan_viol_cap`

## Requirements
- R1: After reset, irq, cmd_busy and every result field (res_member, res_miss, res_ovf, res_port, res_vid, res_page) are 0.
- R2: A report is a cycle with rpt_member or rpt_miss high. A report that arrives while nothing is held is captured, and irq is 1 from the next cycle.
- R3: If rpt_member and rpt_miss are both high in the same cycle, the capture records a miss only: res_miss=1 and res_member=0.
- R4: While a violation is held, further reports are dropped. The details that get-and-clear returns are those of the first report.
- R5: A dropped report sets the overflow bit. Get-and-clear returns it in res_ovf and clears it.
- R6: Get-and-clear is cmd_start=1 with cmd_op=3'b101 while cmd_busy=0. cmd_busy is 1 for exactly the next cycle. One cycle after that, cmd_busy is 0 and the result fields hold the capture: res_port, res_vid = rpt_vid[11:0], and res_page = rpt_vid[12].
- R7: irq is 0 in the cycle after cmd_busy was 1. A report on that clearing edge is dropped and sets overflow. A report in the following cycle is captured again.
- R8: Get-and-clear with nothing held returns res_member=0, res_miss=0, res_port=0, res_vid=0 and res_page=0.
- R9: cmd_start with any other opcode is ignored: cmd_busy stays 0, and irq and the result fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_member | input | 1 | Member violation report strobe |
| rpt_miss | input | 1 | Miss violation report strobe |
| rpt_port | input | PORT_W | Source port of the violating frame |
| rpt_vid | input | VID_W+1 | Violating VLAN ID; top bit is the page bit |
| cmd_start | input | 1 | Host command strobe |
| cmd_op | input | 3 | Host opcode (3'b101 = get-and-clear) |
| cmd_busy | output | 1 | Command in progress |
| irq | output | 1 | Level interrupt, high while a violation is held |
| res_member | output | 1 | Returned member-violation flag |
| res_miss | output | 1 | Returned miss-violation flag |
| res_ovf | output | 1 | Returned overflow flag |
| res_port | output | PORT_W | Returned source port |
| res_vid | output | VID_W | Returned VLAN ID, low bits |
| res_page | output | 1 | Returned VLAN ID page bit |

## Verification
The assertions check the following on every cycle:
- capture from the idle state;
- that the held details stay unchanged while further reports arrive;
- overflow setting;
- miss priority;
- the one-cycle busy pulse;
- that the interrupt is low after a clear.

The bench's scenarios cover the rest. They show, for every port and each violation kind, that the values returned to the host are correct. They also cover the report that lands on the clearing edge, the empty get-and-clear, and other opcodes being ignored.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  localparam int OPC_W = 3;
  typedef enum logic [OPC_W-1:0] {
    VVC_OP_IDLE   = 3'b000,
    VVC_OP_GETCLR = 3'b101
  } vvc_opc_e;
endpackage

// File: rtl/vvc_cmd.sv
module vvc_cmd
  import vvc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [OPC_W-1:0] cmd_op,
  output logic             busy
);
  logic go;
  assign go = cmd_start && !busy && (cmd_op == VVC_OP_GETCLR);

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= go;
  end

  // R6
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R9
  other_op_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && cmd_op != VVC_OP_GETCLR) |=> !busy);
endmodule

// File: rtl/vvc_capture.sv
module vvc_capture #(
  parameter int PORT_W = 4,
  parameter int VID_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_member,
  input  logic              rpt_miss,
  input  logic [PORT_W-1:0] rpt_port,
  input  logic [VID_W:0]    rpt_vid,
  input  logic              clr,
  output logic              pend,
  output logic              cap_member,
  output logic              cap_miss,
  output logic              ovf,
  output logic [PORT_W-1:0] cap_port,
  output logic [VID_W:0]    cap_vid
);
  logic hit, take;
  assign hit  = rpt_member || rpt_miss;
  assign take = hit && !pend && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      cap_member <= 1'b0;
      cap_miss   <= 1'b0;
      cap_port   <= '0;
      cap_vid    <= '0;
    end else if (clr) begin
      pend       <= 1'b0;
      cap_member <= 1'b0;
      cap_miss   <= 1'b0;
    end else if (take) begin
      pend       <= 1'b1;
      cap_miss   <= rpt_miss;
      cap_member <= rpt_member && !rpt_miss;
      cap_port   <= rpt_port;
      cap_vid    <= rpt_vid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       ovf <= 1'b0;
    else if (hit && (pend || clr)) ovf <= 1'b1;
    else if (clr)                  ovf <= 1'b0;
  end

  // R2
  capture_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !pend && !clr) |=> pend);

  // R3
  miss_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (rpt_member && rpt_miss && !pend && !clr) |=> (cap_miss && !cap_member));

  // R4
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> (pend && $stable(cap_port) && $stable(cap_vid)
                        && $stable(cap_miss) && $stable(cap_member)));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && pend) |=> ovf);

  // R7
  clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pend);
endmodule

// File: rtl/vvc_result.sv
module vvc_result #(
  parameter int PORT_W = 4,
  parameter int VID_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              pend,
  input  logic              cap_member,
  input  logic              cap_miss,
  input  logic              ovf,
  input  logic [PORT_W-1:0] cap_port,
  input  logic [VID_W:0]    cap_vid,
  output logic              res_member,
  output logic              res_miss,
  output logic              res_ovf,
  output logic [PORT_W-1:0] res_port,
  output logic [VID_W-1:0]  res_vid,
  output logic              res_page
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_member <= 1'b0;
      res_miss   <= 1'b0;
      res_ovf    <= 1'b0;
      res_port   <= '0;
      res_vid    <= '0;
      res_page   <= 1'b0;
    end else if (load) begin
      res_member <= pend && cap_member;
      res_miss   <= pend && cap_miss;
      res_ovf    <= ovf;
      res_port   <= pend ? cap_port : '0;
      res_vid    <= pend ? cap_vid[VID_W-1:0] : '0;
      res_page   <= pend && cap_vid[VID_W];
    end
  end

  // R8
  empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !pend) |=> (!res_member && !res_miss && res_port == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(res_port) && $stable(res_vid) && $stable(res_ovf)));
endmodule

// File: rtl/vlan_viol_cap.sv
module vlan_viol_cap
  import vvc_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int VID_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_member,
  input  logic              rpt_miss,
  input  logic [PORT_W-1:0] rpt_port,
  input  logic [VID_W:0]    rpt_vid,
  input  logic              cmd_start,
  input  logic [OPC_W-1:0]  cmd_op,
  output logic              cmd_busy,
  output logic              irq,
  output logic              res_member,
  output logic              res_miss,
  output logic              res_ovf,
  output logic [PORT_W-1:0] res_port,
  output logic [VID_W-1:0]  res_vid,
  output logic              res_page
);
  logic              pend, cap_member, cap_miss, ovf;
  logic [PORT_W-1:0] cap_port;
  logic [VID_W:0]    cap_vid;

  vvc_cmd u_cmd (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op), .busy(cmd_busy)
  );

  vvc_capture #(.PORT_W(PORT_W), .VID_W(VID_W)) u_cap (
    .clk(clk), .rst(rst), .rpt_member(rpt_member), .rpt_miss(rpt_miss),
    .rpt_port(rpt_port), .rpt_vid(rpt_vid), .clr(cmd_busy), .pend(pend),
    .cap_member(cap_member), .cap_miss(cap_miss), .ovf(ovf),
    .cap_port(cap_port), .cap_vid(cap_vid)
  );

  vvc_result #(.PORT_W(PORT_W), .VID_W(VID_W)) u_res (
    .clk(clk), .rst(rst), .load(cmd_busy), .pend(pend),
    .cap_member(cap_member), .cap_miss(cap_miss), .ovf(ovf),
    .cap_port(cap_port), .cap_vid(cap_vid), .res_member(res_member),
    .res_miss(res_miss), .res_ovf(res_ovf), .res_port(res_port),
    .res_vid(res_vid), .res_page(res_page)
  );

  assign irq = pend;

  // R7
  irq_low_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> !irq);
endmodule

// File: tb/vlan_viol_cap_bench.sv
module vlan_viol_cap_bench;
  localparam int PORT_W = 4;
  localparam int VID_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rpt_member = 1'b0, rpt_miss = 1'b0;
  logic [PORT_W-1:0] rpt_port = '0;
  logic [VID_W:0] rpt_vid = '0;
  logic cmd_start = 1'b0;
  logic [2:0] cmd_op = 3'b000;
  logic cmd_busy, irq, res_member, res_miss, res_ovf, res_page;
  logic [PORT_W-1:0] res_port;
  logic [VID_W-1:0] res_vid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vlan_viol_cap #(.PORT_W(PORT_W), .VID_W(VID_W)) u_vlan_viol_cap (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report(input logic m, input logic ms, input logic [PORT_W-1:0] p,
                        input logic [VID_W:0] v);
    rpt_member = m; rpt_miss = ms; rpt_port = p; rpt_vid = v;
    @(negedge clk);
    rpt_member = 0; rpt_miss = 0;
  endtask

  task automatic getclr();
    cmd_start = 1; cmd_op = 3'b101;
    @(negedge clk);
    cmd_start = 0; cmd_op = 3'b000;
    chk("R6 busy", {31'd0, cmd_busy}, 1);
    @(negedge clk);
    chk("R6 busy end", {31'd0, cmd_busy}, 0);
    chk("R7 irq low", {31'd0, irq}, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 busy", {31'd0, cmd_busy}, 0);
    chk("R1 result", {25'd0, res_member, res_miss, res_ovf, res_page, res_port}, 0);
    chk("R1 vid", {20'd0, res_vid}, 0);

    // R8: get-and-clear with nothing held
    getclr();
    chk("R8 flags", {29'd0, res_member, res_miss, res_page}, 0);
    chk("R8 port/vid", {16'd0, res_port, res_vid}, 0);

    // Sweep: every port, each kind, optional second (dropped) report
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 3; k++) begin
        logic em, ems, second;
        logic [VID_W:0] v;
        v = 13'((p * 37 + k * 1013 + 5) % 8192);
        em = (k != 1);
        ems = (k != 0);
        second = ((p + k) % 2) == 1;
        report(em, ems, 4'(p), v);
        chk("R2 irq", {31'd0, irq}, 1);
        if (second) begin
          report(1'b1, 1'b0, 4'(15 - p), ~v);
          chk("R4 irq held", {31'd0, irq}, 1);
        end
        getclr();
        chk("R3 flags", {30'd0, res_member, res_miss}, {30'd0, em && !ems, ems});
        chk("R6 port", {28'd0, res_port}, p);
        chk("R6 vid", {19'd0, res_page, res_vid}, {19'd0, v});
        chk("R5 ovf", {31'd0, res_ovf}, {31'd0, second});
      end
    end

    // R9: other opcodes ignored
    report(1'b1, 1'b0, 4'd9, 13'h1abc);
    for (int op = 0; op < 8; op++) begin
      if (op == 5) continue;
      cmd_start = 1; cmd_op = 3'(op);
      @(negedge clk);
      cmd_start = 0;
      chk("R9 no busy", {31'd0, cmd_busy}, 0);
      chk("R9 irq kept", {31'd0, irq}, 1);
      chk("R9 result kept", {28'd0, res_port}, 15);
    end
    getclr();
    chk("R9 capture intact", {19'd0, res_page, res_vid}, 32'h1abc);

    // R7: report on the clearing edge is dropped and counted
    report(1'b0, 1'b1, 4'd3, 13'h0123);
    cmd_start = 1; cmd_op = 3'b101;
    @(negedge clk);
    cmd_start = 0;
    rpt_miss = 1; rpt_port = 4'd7; rpt_vid = 13'h0777;
    @(negedge clk);
    rpt_miss = 0;
    chk("R7 clear-edge drop irq", {31'd0, irq}, 0);
    chk("R6 port before drop", {28'd0, res_port}, 3);
    report(1'b1, 1'b0, 4'd11, 13'h1055);
    chk("R7 recapture irq", {31'd0, irq}, 1);
    getclr();
    chk("R7 recapture port", {28'd0, res_port}, 11);
    chk("R7 overflow from clear edge", {31'd0, res_ovf}, 1);
    getclr();
    chk("R5 ovf cleared", {31'd0, res_ovf}, 0);
    chk("R8 empty flags", {30'd0, res_member, res_miss}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule